// File: doc/BRIEF.md
# Address-Parity Check-Bit Folding

This block sits in the memory data path between the ECC code generator/checker and the DRAM storage. On a write, it takes the check bits produced for a data word and folds in two address signatures. The first is the even parity of the row address. It is XORed into one chosen check bit. The second is the even parity of the column address. It is XORed into a different chosen check bit. The modified check bits are what the DRAM stores.

On a read, the same transform is applied with the row and column address of the read. If the read reaches the cell that was written, the two contributions cancel and the original check bits come back. If one row or column address line is stuck or flipped, the address parity differs between write and read. The recovered check bits then disagree with the data in one known position, and the downstream ECC checker reports an error instead of returning data from the wrong cell quietly.

The block is purely combinational. A direction flag travels with each beat and goes out with the result. Beats cross a valid/ready handshake with no storage. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. Back-pressure from the consumer therefore reaches the producer directly. While `in_valid` is high, the payload must stay steady until `out_ready` is seen high.

Top module: `addr_par_fold`

## Requirements
- R1: `out_chk[ROW_POS]` equals `in_chk[ROW_POS]` XOR the XOR of all bits of `in_row`, where the XOR of the bits is the even-parity bit of the row field.
- R2: `out_chk[COL_POS]` equals `in_chk[COL_POS]` XOR the XOR of all bits of `in_col`.
- R3: Every check bit other than positions ROW_POS and COL_POS passes from `in_chk` to `out_chk` unchanged.
- R4: The transform is identical for both directions (`in_dir` = 0 write fold, 1 read strip), and `out_dir` equals `in_dir`.
- R5: Folding with an address and then stripping with the same address returns the original check bits exactly.
- R6: If the read row address differs from the write row address in exactly one bit, the recovered check bits differ from the original only in bit ROW_POS.
- R7: If the read column address differs from the write column address in exactly one bit, the recovered check bits differ from the original only in bit COL_POS.
- R8: If both the row and the column address each differ in exactly one bit, the recovered check bits differ from the original in exactly bits ROW_POS and COL_POS.
- R9: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, so a beat moves only when valid and ready are both high. With `in_valid` low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Beat offered by the producer |
| in_ready | output | 1 | Block can accept the beat (follows out_ready) |
| in_dir | input | 1 | 0 = write fold, 1 = read strip |
| in_chk | input | CHK_W | Check bits entering the block |
| in_row | input | ROW_W | Row address of the access |
| in_col | input | COL_W | Column address of the access |
| out_valid | output | 1 | Beat offered to the consumer |
| out_ready | input | 1 | Consumer accepts the beat |
| out_dir | output | 1 | Direction flag carried with the beat |
| out_chk | output | CHK_W | Check bits with address parity folded or stripped |

## Verification
The hard case is an address fault: a read that uses an address one bit away from the address of the write. A single instance never shows a fault, so the bench chains two instances. The first folds with the write address. The second strips with a read address that is the write address XOR a one-hot mask. The bench walks every row bit, every column bit and every pairing of the two, for every address of a narrow configuration and several check-bit patterns. It then compares the recovered check bits against the original with the expected single-bit or double-bit flip.

// File: rtl/apf_pkg.sv
package apf_pkg;
  localparam logic DIR_WRITE = 1'b0;
  localparam logic DIR_READ  = 1'b1;
endpackage

// File: rtl/apf_parity.sv
module apf_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec,
  output logic         par
);
  logic [W:0] acc;
  assign acc[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign acc[i+1] = acc[i] ^ vec[i];
  end
  assign par = acc[W];
endmodule

// File: rtl/apf_mask.sv
module apf_mask #(
  parameter int CHK_W   = 8,
  parameter int ROW_POS = 6,
  parameter int COL_POS = 7
) (
  input  logic             row_par,
  input  logic             col_par,
  output logic [CHK_W-1:0] mask
);
  for (genvar i = 0; i < CHK_W; i++) begin : g_bit
    if (i == ROW_POS && i == COL_POS) begin : g_both
      assign mask[i] = row_par ^ col_par;
    end else if (i == ROW_POS) begin : g_row
      assign mask[i] = row_par;
    end else if (i == COL_POS) begin : g_col
      assign mask[i] = col_par;
    end else begin : g_none
      assign mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/addr_par_fold.sv
module addr_par_fold #(
  parameter int CHK_W   = 8,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 11,
  parameter int ROW_POS = 6,
  parameter int COL_POS = 7
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_dir,
  input  logic [CHK_W-1:0] in_chk,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_dir,
  output logic [CHK_W-1:0] out_chk
);
  logic             row_par;
  logic             col_par;
  logic [CHK_W-1:0] fold_mask;

  apf_parity #(.W(ROW_W)) u_row_par (.vec(in_row), .par(row_par));
  apf_parity #(.W(COL_W)) u_col_par (.vec(in_col), .par(col_par));

  apf_mask #(.CHK_W(CHK_W), .ROW_POS(ROW_POS), .COL_POS(COL_POS)) u_mask (
    .row_par(row_par),
    .col_par(col_par),
    .mask   (fold_mask)
  );

  // XOR is its own inverse: the same mask folds on write and strips on read.
  assign out_chk   = in_chk ^ fold_mask;
  assign out_dir   = in_dir;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/addr_par_fold_chk.sv
module addr_par_fold_chk #(
  parameter int CHK_W   = 8,
  parameter int ROW_W   = 14,
  parameter int COL_W   = 11,
  parameter int ROW_POS = 6,
  parameter int COL_POS = 7
) (
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_dir,
  input logic [CHK_W-1:0] in_chk,
  input logic [ROW_W-1:0] in_row,
  input logic [COL_W-1:0] in_col,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_dir,
  input logic [CHK_W-1:0] out_chk
);
  logic [CHK_W-1:0] diff;
  logic             known;
  assign diff  = out_chk ^ in_chk;
  assign known = !$isunknown({in_chk, in_row, in_col, out_chk, in_dir, out_dir,
                              in_valid, out_valid, in_ready, out_ready});

  always_comb begin
    if (known) begin
      a_r1_row_fold: assert (diff[ROW_POS] == (^in_row) || ROW_POS == COL_POS)
        else $error("row parity not folded");
      a_r2_col_fold: assert (diff[COL_POS] == (^in_col) || ROW_POS == COL_POS)
        else $error("col parity not folded");
      a_r3_other_bits: assert ($countones(diff) <= 2)
        else $error("extra check bits changed");
      a_r4_dir_carried: assert (out_dir == in_dir)
        else $error("direction flag lost");
      a_r9_handshake: assert (out_valid == in_valid && in_ready == out_ready)
        else $error("handshake not passed through");
    end
  end
endmodule

bind addr_par_fold addr_par_fold_chk #(
  .CHK_W(CHK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ROW_POS(ROW_POS), .COL_POS(COL_POS)
) chk_i (
  .in_valid(in_valid), .in_ready(in_ready), .in_dir(in_dir), .in_chk(in_chk),
  .in_row(in_row), .in_col(in_col), .out_valid(out_valid), .out_ready(out_ready),
  .out_dir(out_dir), .out_chk(out_chk)
);

// File: tb/addr_par_fold_tb_top.sv
module addr_par_fold_tb_top;
  localparam int CW = 8;
  localparam int RW = 4;
  localparam int KW = 4;
  localparam int RP = 5;
  localparam int KP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic          w_valid, w_ready, w_dir, w_ovalid, w_odir;
  logic [CW-1:0] w_chk, w_ochk;
  logic [RW-1:0] w_row, r_row;
  logic [KW-1:0] w_col, r_col;
  logic          r_ready, r_ovalid, r_odir, r_iready;
  logic [CW-1:0] r_ochk;

  addr_par_fold #(.CHK_W(CW), .ROW_W(RW), .COL_W(KW), .ROW_POS(RP), .COL_POS(KP)) dut_i (
    .in_valid(w_valid), .in_ready(w_ready), .in_dir(w_dir), .in_chk(w_chk),
    .in_row(w_row), .in_col(w_col), .out_valid(w_ovalid), .out_ready(r_iready),
    .out_dir(w_odir), .out_chk(w_ochk)
  );

  addr_par_fold #(.CHK_W(CW), .ROW_W(RW), .COL_W(KW), .ROW_POS(RP), .COL_POS(KP)) rd_i (
    .in_valid(w_ovalid), .in_ready(r_iready), .in_dir(1'b1), .in_chk(w_ochk),
    .in_row(r_row), .in_col(r_col), .out_valid(r_ovalid), .out_ready(r_ready),
    .out_dir(r_odir), .out_chk(r_ochk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [CW-1:0] pattern(input int p, input int a);
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hA5;
      default: return CW'(a * 37 + 11);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    w_valid = 0; w_dir = 0; w_chk = '0; w_row = '0; w_col = '0;
    r_row = '0; r_col = '0; r_ready = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle valid", {31'd0, r_ovalid}, 32'd0);
    check("R9 idle ready", {31'd0, w_ready}, 32'd0);

    // R9: handshake passes through both stages in the same cycle
    for (int v = 0; v < 4; v++) begin
      @(posedge clk); #1;
      w_valid = v[0]; r_ready = v[1];
      @(negedge clk);
      check("R9 valid", {31'd0, r_ovalid}, {31'd0, v[0]});
      check("R9 ready", {31'd0, w_ready},  {31'd0, v[1]});
    end

    // R1 R2 R3 R4 R5: sweep all addresses and several check patterns
    for (int a = 0; a < 256; a++) begin
      for (int p = 0; p < 4; p++) begin
        logic [CW-1:0] c, e;
        @(posedge clk); #1;
        w_valid = 1; w_dir = p[0];
        c = pattern(p, a);
        w_chk = c; w_row = RW'(a); w_col = KW'(a >> 4);
        r_row = w_row; r_col = w_col;
        e = c;
        e[RP] = e[RP] ^ (^w_row);
        e[KP] = e[KP] ^ (^w_col);
        @(negedge clk);
        check("R1 R2 R3 fold", {24'd0, w_ochk}, {24'd0, e});
        check("R4 dir", {30'd0, w_odir, r_odir}, {30'd0, p[0], 1'b1});
        check("R5 round trip", {24'd0, r_ochk}, {24'd0, c});
      end
    end

    // R6 R7 R8: one-bit address faults between write and read
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 4; k++) begin
        logic [CW-1:0] c, e;
        c = pattern(k, a);
        @(posedge clk); #1;
        w_chk = c; w_row = RW'(a); w_col = KW'(a >> 4);
        r_row = w_row ^ RW'(1 << k); r_col = w_col;
        @(negedge clk);
        e = c; e[RP] = ~e[RP];
        check("R6 row fault", {24'd0, r_ochk}, {24'd0, e});
        @(posedge clk); #1;
        r_row = w_row; r_col = w_col ^ KW'(1 << k);
        @(negedge clk);
        e = c; e[KP] = ~e[KP];
        check("R7 col fault", {24'd0, r_ochk}, {24'd0, e});
        for (int j = 0; j < 4; j++) begin
          @(posedge clk); #1;
          r_row = w_row ^ RW'(1 << k); r_col = w_col ^ KW'(1 << j);
          @(negedge clk);
          e = c; e[RP] = ~e[RP]; e[KP] = ~e[KP];
          check("R8 both fault", {24'd0, r_ochk}, {24'd0, e});
        end
      end
    end

    finish_run();
  end
endmodule